// File: doc/BRIEF.md
# Clear-on-read interrupt status and mask register

This block is an 8-bit status/mask register pair for the interrupt section of an instrument-bus talker/listener controller. Both registers sit at one bus offset. A read returns the status view and a write loads the mask. Five event pulses latch into sticky status bits: service request, command out, lockout change, remote change and addressed-state change. Reading the register clears these bits. The view also reports two live state bits, lockout and remote, and a summary interrupt bit.

A read cycle is marked by `rd_strobe` and may last one or more clock cycles. While the strobe is high the status bits are frozen. Any event seen during that time is held in a per-bit pending flag. On the first clock edge with the strobe low again, the bits are cleared and the pending events (plus any event in that same cycle) are written in, so no event is lost. A write sets the five interrupt enables and two DMA direction control outputs.

The summary interrupt is the OR of every status bit ANDed with its enable. A companion register's enabled interrupt terms arrive already masked and are also ORed in. `irq_out` drives that summary active high. All bus signals are plain strobes, because the register access carries no stream data.

Top module: `irq_stat_mask_reg`

## Requirements
- R1: After reset, `rd_data` is 0x00, `irq_out` is 0, and `dma_out_en`/`dma_in_en` are 0.
- R2: With no read in progress, an event pulse sets its status bit at the next clock edge. The status view bits are: 7 summary, 6 service request, 5 lockout state, 4 remote state, 3 command out, 2 lockout change, 1 remote change, 0 addressed-state change. `evt_pulse` bits 4..0 map to view bits 6,3,2,1,0.
- R3: On the first clock edge where `rd_strobe` is low after having been high, every event status bit with no pending or simultaneous event becomes 0.
- R4: While `rd_strobe` is high the event status bits do not change. An event seen during the read is set at the first edge after the read ends.
- R5: Event status bits set whatever the enables hold.
- R6: `irq_out` = OR over the five events of (status AND enable), ORed with OR of `peer_irq_vec`.
- R7: A write with `wr_en` loads the mask. Bit 6 enables service request. Bit 5 drives `dma_out_en`. Bit 4 drives `dma_in_en`. Bits 3..0 enable command out, lockout change, remote change and addressed-state change. Bit 7 is ignored.
- R8: View bits 5 and 4 follow `lok_state` and `rem_state` directly. A read does not clear them, and they never raise `irq_out`.
- R9: View bit 7 always equals `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | High during a read cycle of the shared offset |
| wr_en | input | 1 | One-cycle write strobe for the mask |
| wr_data | input | 8 | Mask write data |
| rd_data | output | 8 | Status view |
| evt_pulse | input | 5 | Event pulses: srq, co, lokc, remc, adsc (bit 4..0) |
| lok_state | input | 1 | Live lockout state |
| rem_state | input | 1 | Live remote state |
| peer_irq_vec | input | PEER_W | Already-masked interrupt terms of the companion register |
| dma_out_en | output | 1 | DMA-out direction control |
| dma_in_en | output | 1 | DMA-in direction control |
| irq_out | output | 1 | Summary interrupt, active high |

## Verification
The hazard is an event pulse landing in the same cycle as a read. This includes the cycle the read strobe is held, and the exact edge where the read ends and the clear is applied. The bench holds the strobe across several cycles and fires events at each position. It then checks three things: the view stays frozen during the read, the bit appears exactly one edge after the strobe drops, and an event with no pending partner on that edge is not lost to the clear. An exhaustive sweep of all event patterns against all enable patterns checks the interrupt arithmetic.

// File: rtl/irq_sr_pkg.sv
package irq_sr_pkg;
  localparam int NUM_EVT = 5;
  localparam int REG_W   = 8;

  typedef struct packed {
    logic       srq_en;
    logic       dma_out;
    logic       dma_in;
    logic [3:0] lo_en;   // co, lokc, remc, adsc
  } mask_t;

  function automatic logic [NUM_EVT-1:0] mask_enables(input mask_t m);
    return {m.srq_en, m.lo_en};
  endfunction
endpackage

// File: rtl/isr_read_track.sv
module isr_read_track (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_strobe,
  output logic rd_end
);
  logic rd_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_prev_q <= 1'b0;
    else        rd_prev_q <= rd_strobe;
  end

  assign rd_end = rd_prev_q & ~rd_strobe;

  assert_end_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end |=> !rd_end);
endmodule

// File: rtl/isr_evt_bit.sv
module isr_evt_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_strobe,
  input  logic rd_end,
  input  logic evt,
  output logic stat_q
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (rd_strobe) begin
      pend_q <= pend_q | evt;
    end else if (rd_end) begin
      stat_q <= pend_q | evt;
      pend_q <= 1'b0;
    end else begin
      stat_q <= stat_q | evt;
    end
  end

  assert_hold_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> stat_q == $past(stat_q));
  assert_pend_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && evt) |=> pend_q);
  assert_pend_applied_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && pend_q) |=> stat_q);
  assert_clear_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && !pend_q && !evt) |=> !stat_q);
  assert_set_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe && !rd_end && evt) |=> stat_q);
endmodule

// File: rtl/isr_mask_reg.sv
module isr_mask_reg
  import irq_sr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output mask_t            mask_q
);
  logic unused_rsvd;
  assign unused_rsvd = wr_data[REG_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= mask_t'(wr_data[REG_W-2:0]);
  end

  assert_dma_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mask_q.dma_out == $past(wr_data[5])) && (mask_q.dma_in == $past(wr_data[4])));
  assert_hold_nowr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/irq_stat_mask_reg.sv
module irq_stat_mask_reg
  import irq_sr_pkg::*;
#(
  parameter int PEER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_strobe,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic              lok_state,
  input  logic              rem_state,
  input  logic [PEER_W-1:0] peer_irq_vec,
  output logic              dma_out_en,
  output logic              dma_in_en,
  output logic              irq_out
);
  logic              rd_end;
  logic [NUM_EVT-1:0] stat;
  mask_t             mask_q;
  logic [NUM_EVT-1:0] en;

  isr_read_track u_track (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_end(rd_end)
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    isr_evt_bit u_bit (
      .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_end(rd_end),
      .evt(evt_pulse[i]), .stat_q(stat[i])
    );
  end

  isr_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mask_q(mask_q)
  );

  assign en         = mask_enables(mask_q);
  assign irq_out    = (|(stat & en)) | (|peer_irq_vec);
  assign dma_out_en = mask_q.dma_out;
  assign dma_in_en  = mask_q.dma_in;
  assign rd_data    = {irq_out, stat[4], lok_state, rem_state, stat[3:0]};

  assert_view_int_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] == irq_out);
  assert_no_irq_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6] == 1'b0 && rd_data[3:0] == 4'h0 && peer_irq_vec == '0) |-> !irq_out);
  assert_live_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5] == lok_state) && (rd_data[4] == rem_state));
endmodule

// File: tb/irq_stat_mask_reg_tb_top.sv
module irq_stat_mask_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_strobe = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [4:0] evt_pulse = '0;
  logic lok_state = 1'b0, rem_state = 1'b0;
  logic [PW-1:0] peer_irq_vec = '0;
  logic dma_out_en, dma_in_en, irq_out;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_stat_mask_reg #(.PEER_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .evt_pulse(evt_pulse),
    .lok_state(lok_state), .rem_state(rem_state), .peer_irq_vec(peer_irq_vec),
    .dma_out_en(dma_out_en), .dma_in_en(dma_in_en), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  function automatic logic [7:0] view(input logic [4:0] st, input logic l, input logic r,
                                      input logic irq);
    return {irq, st[4], l, r, st[3:0]};
  endfunction

  task automatic do_write(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1; step(); wr_en = 1'b0;
  endtask

  task automatic do_read1(); // one-cycle read; returns after clear applied
    rd_strobe = 1'b1; step(); rd_strobe = 1'b0; step();
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1'b1; step();
    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", irq_out, 0);
    chk("R1 dma", {dma_out_en, dma_in_en}, 2'b00);

    // R7 write layout, bit7 ignored
    do_write(8'hB0);
    chk("R7 dma", {dma_out_en, dma_in_en}, 2'b11);
    chk("R7 bit7 ignored irq", irq_out, 0);
    do_write(8'h20);
    chk("R7 dma out only", {dma_out_en, dma_in_en}, 2'b10);

    // exhaustive enable x event sweep: R2 R5 R6 R9 R3
    for (int e = 0; e < 32; e++) begin
      for (int v = 0; v < 32; v++) begin
        logic [4:0] en5, ev5;
        logic expi;
        en5 = e[4:0]; ev5 = v[4:0];
        do_write({1'b1, en5[4], 2'b00, en5[3:0]});
        evt_pulse = ev5; step(); evt_pulse = '0;
        expi = |(ev5 & en5);
        chk("R2/R5 status", rd_data[6:0], view(ev5, 1'b0, 1'b0, 1'b0) & 8'h7F);
        chk("R6 irq", irq_out, expi);
        chk("R9 bit7", rd_data[7], expi);
        do_read1();
        chk("R3 cleared", rd_data, 8'h00);
      end
    end

    // R6 peer terms
    do_write(8'h00);
    for (int b = 0; b < PW; b++) begin
      peer_irq_vec = PW'(1) << b; step();
      chk("R6 peer", irq_out, 1);
    end
    peer_irq_vec = '0; step();
    chk("R6 peer off", irq_out, 0);

    // R8 live bits: not cleared, no irq even with all enables
    do_write(8'h4F);
    lok_state = 1'b1; rem_state = 1'b1; step();
    chk("R8 live", rd_data, 8'h30);
    do_read1();
    chk("R8 not cleared", rd_data, 8'h30);
    chk("R8 no irq", irq_out, 0);
    lok_state = 1'b0; step();
    chk("R8 follows", rd_data, 8'h10);
    rem_state = 1'b0;

    // R4 event during long read: frozen view, set after read ends
    evt_pulse = 5'b00001; step(); evt_pulse = '0;
    rd_strobe = 1'b1; step();
    evt_pulse = 5'b10000; step(); evt_pulse = '0;
    chk("R4 frozen", rd_data, 8'h81);
    evt_pulse = 5'b00100; step(); evt_pulse = '0;
    chk("R4 frozen2", rd_data, 8'h81);
    rd_strobe = 1'b0; step();
    chk("R4 pending applied", rd_data, view(5'b10100, 1'b0, 1'b0, 1'b1));
    do_read1();
    chk("R3 clear after pend", rd_data, 8'h00);

    // R4 event on the exact clear edge is kept
    rd_strobe = 1'b1; step(); rd_strobe = 1'b0;
    evt_pulse = 5'b00010; step(); evt_pulse = '0;
    chk("R4 evt on clear edge", rd_data, 8'h82);
    do_read1();
    chk("R3 clear", rd_data, 8'h00);

    // R2 event right after clear edge sets normally
    evt_pulse = 5'b01000; step(); evt_pulse = '0;
    chk("R2 idle set", rd_data, 8'h88);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule